// File: doc/BRIEF.md
# Serial Flash Security-Register Erase Responder

This block is the device-side command logic of a serial flash slave for erasing its three one-time-protectable security registers. It watches a single-bit SPI link (chip select, clock, data in) through synchronizers running on the system clock. Data in is sampled on each rising SPI clock edge, so clock idle levels of both mode 0 and mode 3 work. It decodes an 8-bit command followed, for the erase command, by a 24-bit address sent most significant bit first.

The block keeps a write-enable latch and a BUSY flag. A valid erase starts a self-timed erase that lasts a fixed number of system clocks. On the first cycle it pulses a strobe naming the register to erase. When the erase finishes, BUSY drops and the write-enable latch clears. While an erase is running, a host can keep reading the status byte to poll BUSY. The lock bits come from permanent storage outside the block and are an input here.

Top module: `secreg_erase_slave`

## Requirements
- R1: After reset, busy, wel, erase_go and spi_miso are all 0.
- R2: Command 06h, with chip select rising after exactly 8 bits while not busy, sets wel (status bit 1).
- R3: Command 05h returns the status byte {6'b0, wel, busy} MSB first on spi_miso, one bit per falling SPI clock edge after the 8th rising edge. It is served while an erase is running.
- R4: Command 44h with a 24-bit address, wel = 1, a valid address and the target unlocked, pulses erase_go for one cycle with erase_sel = address bits 13:12. busy is then high for exactly ERASE_CYCLES system clocks.
- R5: When an erase finishes, busy and wel both return to 0.
- R6: An erase command received while wel = 0 is ignored: no erase_go and busy stays 0.
- R7: Register n (1..3) is protected by lock_bits[n-1]. An erase aimed at a locked register is ignored, and wel is left unchanged.
- R8: An address whose bits 23:16 are not 00h, whose bits 11:8 are not 0, or whose bits 15:12 are not 1, 2 or 3 makes the erase be ignored, and wel is left unchanged. Bits 7:0 are don't-care.
- R9: An erase command where chip select rises after any bit count other than exactly 32 is ignored.
- R10: While busy is 1, write-enable and erase commands are ignored.
- R11: Commands work the same whether the SPI clock idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (0 when not shifting status) |
| lock_bits | input | 3 | Permanent lock per security register, bit n-1 for register n |
| busy | output | 1 | Erase in progress |
| wel | output | 1 | Write-enable latch |
| status | output | 8 | Status byte {6'b0, wel, busy} |
| erase_go | output | 1 | One-cycle pulse when an erase starts |
| erase_sel | output | 2 | Register being erased (1..3) |

## Verification
The assertions watch, on every cycle, the conditions under which an erase may start: wel set, a nonzero and unlocked target, no erase already running. They also check that BUSY spans exactly the erase length, that the end of an erase leaves wel clear, and that wel never rises while busy. The bench scenarios cover the serial side, which no single-cycle property captures: the status bits coming out in order on spi_miso, including during an erase, each way a malformed address or a wrong bit count gets the command discarded, and identical results with either clock idle level.

// File: rtl/secreg_erase_slave.sv
module secreg_erase_slave #(
  parameter int ERASE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [2:0] lock_bits,
  output logic       busy,
  output logic       wel,
  output logic [7:0] status,
  output logic       erase_go,
  output logic [1:0] erase_sel
);
  localparam int TW = $clog2(ERASE_CYCLES + 1);
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'h44;

  logic [1:0]    sck_m, cs_m, mosi_m;
  logic          sck_d, cs_d;
  logic [31:0]   sh;
  logic [5:0]    bitcnt;
  logic          rd_on;
  logic [2:0]    rd_idx;
  logic [TW-1:0] tmr;

  wire sck_s    = sck_m[1];
  wire cs_s     = cs_m[1];
  wire mosi_s   = mosi_m[1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_rise  = cs_s & ~cs_d;

  wire [7:0]  op8  = sh[7:0];
  wire [7:0]  op32 = sh[31:24];
  wire [23:0] addr = sh[23:0];
  wire [1:0]  idx  = addr[13:12];
  wire addr_ok = (addr[23:16] == 8'h00) && (addr[15:14] == 2'b00) &&
                 (idx != 2'd0) && (addr[11:8] == 4'h0);
  wire locked  = (idx == 2'd1 && lock_bits[0]) || (idx == 2'd2 && lock_bits[1]) ||
                 (idx == 2'd3 && lock_bits[2]);
  wire wen_hit   = cs_rise && bitcnt == 6'd8 && op8 == OP_WEN && !busy;
  wire erase_hit = cs_rise && bitcnt == 6'd32 && op32 == OP_ERASE && !busy &&
                   wel && addr_ok && !locked;

  assign status = {6'b0, wel, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_m  <= 2'b00;
      cs_m   <= 2'b11;
      mosi_m <= 2'b00;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_m  <= {sck_m[0], spi_sck};
      cs_m   <= {cs_m[0], spi_cs_n};
      mosi_m <= {mosi_m[0], spi_mosi};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
      rd_on  <= 1'b0;
    end else if (cs_s) begin
      bitcnt <= '0;
      rd_on  <= 1'b0;
    end else if (sck_rise) begin
      sh <= {sh[30:0], mosi_s};
      if (bitcnt != 6'd63) bitcnt <= bitcnt + 6'd1;
      if (bitcnt == 6'd7 && {sh[6:0], mosi_s} == OP_STAT) rd_on <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cs_s) begin
      spi_miso <= 1'b0;
      rd_idx   <= '0;
    end else if (sck_fall && rd_on) begin
      spi_miso <= status[3'd7 - rd_idx];
      rd_idx   <= rd_idx + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wel       <= 1'b0;
      erase_go  <= 1'b0;
      erase_sel <= 2'd0;
      tmr       <= '0;
    end else begin
      erase_go <= 1'b0;
      if (erase_hit) begin
        busy      <= 1'b1;
        erase_go  <= 1'b1;
        erase_sel <= idx;
        tmr       <= TW'(ERASE_CYCLES - 1);
      end else if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (wen_hit) wel <= 1'b1;
    end
  end
endmodule

// File: rtl/secreg_erase_chk.sv
module secreg_erase_chk #(
  parameter int ERASE_CYCLES = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic       erase_go,
  input logic [1:0] erase_sel,
  input logic [2:0] lock_bits
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  // R4
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> busy);
  // R4
  go_sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> erase_sel != 2'd0);
  // R6
  go_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> wel);
  // R7
  go_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> !((erase_sel == 2'd1 && lock_bits[0]) || (erase_sel == 2'd2 && lock_bits[1]) ||
                   (erase_sel == 2'd3 && lock_bits[2])));
  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == ERASE_CYCLES);
  // R5
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> !$past(busy));
  // R10
  wel_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> !busy);
endmodule

bind secreg_erase_slave secreg_erase_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel),
  .erase_go(erase_go), .erase_sel(erase_sel), .lock_bits(lock_bits)
);

// File: tb/secreg_erase_slave_test.sv
module secreg_erase_slave_test;
  localparam int E = 2000;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [2:0] lock = 3'b000;
  logic miso, busy, wel, go;
  logic [7:0] stat;
  logic [1:0] sel;
  int total = 0, bad = 0, go_cnt = 0;
  logic [1:0] go_sel = 0;
  logic mode3 = 0;

  always #2.5 clk = ~clk;

  secreg_erase_slave #(.ERASE_CYCLES(E)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .lock_bits(lock), .busy(busy), .wel(wel), .status(stat),
    .erase_go(go), .erase_sel(sel));

  always @(negedge clk) if (go) begin go_cnt++; go_sel = sel; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap(int n); repeat (n) @(negedge clk); endtask

  task automatic cs_lo();
    sck = mode3; gap(H); cs_n = 0; gap(H);
  endtask

  task automatic cs_hi();
    if (!mode3) begin sck = 0; gap(H); end
    cs_n = 1;
  endtask

  task automatic put_bits(logic [39:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 0; mosi = v[i]; gap(H); sck = 1; gap(H);
    end
  endtask

  task automatic cmd(logic [39:0] v, int n);
    cs_lo(); put_bits(v, n); cs_hi(); gap(2 * H);
  endtask

  task automatic read_status(output logic [7:0] s);
    cs_lo(); put_bits(40'h05, 8);
    for (int i = 7; i >= 0; i--) begin
      sck = 0; gap(H); s[i] = miso; sck = 1; gap(H);
    end
    cs_hi(); gap(2 * H);
  endtask

  task automatic erase_cmd(logic [23:0] a);
    cs_lo(); put_bits({8'h44, a}, 32); cs_hi();
  endtask

  task automatic wait_erase(output int dur);
    int w = 0;
    while (!busy && w < 50) begin gap(1); w++; end
    dur = 0;
    while (busy) begin gap(1); dur++; end
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 busy", busy, 0); chk("R1 wel", wel, 0);
    chk("R1 erase_go", go, 0); chk("R1 miso", miso, 0);
    read_status(s); chk("R3 idle status", s, 8'h00);
  endtask

  task automatic t_wren();
    logic [7:0] s;
    cmd(40'h06, 8); chk("R2 wel set", wel, 1);
    read_status(s); chk("R3 status wel", s, 8'h02);
  endtask

  task automatic t_erase_ok();
    int d, g = go_cnt;
    erase_cmd(24'h0010AB); wait_erase(d);
    chk("R4 duration", d, E); chk("R4 one strobe", go_cnt, g + 1);
    chk("R4 sel", go_sel, 1);
    chk("R5 busy clear", busy, 0); chk("R5 wel clear", wel, 0);
  endtask

  task automatic t_no_wel();
    int g = go_cnt;
    erase_cmd(24'h002000); gap(4 * H);
    chk("R6 no strobe", go_cnt, g); chk("R6 not busy", busy, 0);
  endtask

  task automatic t_locked();
    int d, g;
    lock = 3'b010; cmd(40'h06, 8); g = go_cnt;
    erase_cmd(24'h002000); gap(4 * H);
    chk("R7 locked ignored", go_cnt, g); chk("R7 wel kept", wel, 1);
    mode3 = 1;
    erase_cmd(24'h0030FF); wait_erase(d);
    chk("R11 mode3 erase", go_cnt, g + 1); chk("R11 mode3 sel", go_sel, 3);
    chk("R11 mode3 duration", d, E);
    lock = 3'b000; mode3 = 0;
  endtask

  task automatic t_bad_addr();
    int g;
    cmd(40'h06, 8); g = go_cnt;
    erase_cmd(24'h004000); gap(4 * H); chk("R8 idx 4", go_cnt, g);
    erase_cmd(24'h000000); gap(4 * H); chk("R8 idx 0", go_cnt, g);
    erase_cmd(24'h011000); gap(4 * H); chk("R8 high byte", go_cnt, g);
    erase_cmd(24'h001100); gap(4 * H); chk("R8 bits 11:8", go_cnt, g);
    chk("R8 wel kept", wel, 1);
  endtask

  task automatic t_bad_len();
    int g = go_cnt;
    cs_lo(); put_bits({8'h44, 24'h001000}, 31); cs_hi(); gap(4 * H);
    chk("R9 31 bits", go_cnt, g);
    cs_lo(); put_bits({7'h00, 8'h44, 24'h001000, 1'b0}, 33); cs_hi(); gap(4 * H);
    chk("R9 33 bits", go_cnt, g); chk("R9 wel kept", wel, 1);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    int d, g;
    mode3 = 1; g = go_cnt;
    erase_cmd(24'h002000); gap(4 * H);
    chk("R4 sel 2", go_sel, 2);
    read_status(s); chk("R3 status during erase", s, 8'h03);
    cmd(40'h06, 8);
    erase_cmd(24'h001000); gap(4 * H);
    chk("R10 erase while busy", go_cnt, g + 1);
    wait_erase(d);
    chk("R10 wren while busy", wel, 0);
    read_status(s); chk("R3 mode3 status after", s, 8'h00);
    mode3 = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1; gap(4);
    t_reset(); t_wren(); t_erase_ok(); t_no_wel(); t_locked();
    t_bad_addr(); t_bad_len(); t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule